// File: doc/BRIEF.md
# Backtracking Circuit-Setup Switch Controller

This block is the control half of a five-port circuit-switched mesh router. Each port is bidirectional. On the inbound side an upstream neighbour drives a request bit and a data bus and receives a 2-bit answer. On the outbound side the block drives a request bit and a data bus toward the downstream neighbour and receives that neighbour's 2-bit answer. Port 0 faces the local IP wrapper. Ports 1 to 4 face the neighbours in the +X, -X, +Y and -Y directions.

A circuit request arrives as a probe. The probe is a destination address placed on the inbound data bus when the request bit rises. The switch searches depth-first along minimal-path links only. It reserves one profitable output and passes the probe on. When the output answers "blocked", the switch marks that output as explored in state held for that input, and tries the next one. When no candidate is left, it refuses upstream. The search history stays in the switch, so the probe carries nothing but the address.

Once the circuit is up, the crossbar connection passes the input data straight to the reserved output. The connection holds until the request bit is withdrawn.

Top module: `bt_circuit_switch`

## Requirements
- R1: While reset (synchronous, active-low) is applied, and on the first sampled cycle after it, every out_req bit, every out_data lane and every out_ans code reads zero.
- R2: The address has X in bits [CW-1:0] and Y in bits [2*CW-1:CW]. A probe for another node is first offered to the X-direction output that reduces the X distance: port 1 when the destination X is greater than the node X, port 2 when it is smaller. The chosen output's out_req rises on the second rising edge after the input's in_req is first seen high.
- R3: When the X coordinate already matches, or the X-direction output is unavailable, the probe goes to the Y-direction output that reduces the distance: port 3 for a greater Y, port 4 for a smaller Y.
- R4: A probe whose address equals node_addr is routed to port 0. While connected, the answer from the local port (01 ready, 11 busy) is relayed unchanged on the requesting input's out_ans.
- R5: A downstream answer of 10 on a held output releases that output on the next edge. That output is never offered again for the same request, and the search moves to the next unexplored, free, profitable output.
- R6: When no unexplored, free, profitable output remains, the input drives 10 upstream and holds no output until its in_req falls.
- R7: An output is held by at most one input. When several searching inputs select the same free output in one cycle, the lowest-numbered input gets it. A loser sees the output as taken on the next cycle.
- R8: A probe for the local node that finds port 0 already held by another input receives 11.
- R9: When in_req falls, the held output's out_req and the crossbar connection are released on the next rising edge, and out_ans reads 00 after that edge.
- R10: While a circuit is held, out_data of the output equals in_data of its owning input in the same cycle. An output with no owner drives zero.
- R11: During the search cycles, and while a connected downstream answer is 10 or 00, the input's out_ans is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_addr | input | 2*CW | Static address of this node, Y above X |
| in_req | input | 5 | Inbound request bit for each port |
| in_data | input | 5*2*CW | Inbound data for each port; lane p is bits [p*2*CW +: 2*CW] |
| out_ans | output | 10 | Answer to each upstream neighbour; lane p is bits [2p +: 2] |
| out_req | output | 5 | Outbound request bit for each port |
| out_data | output | 5*2*CW | Outbound data for each port |
| in_ans | input | 10 | Answer from each downstream neighbour |

## Verification
The hardest situation to reach is a search that is refused after exploring every candidate: a probe that backtracks twice and then ends refused. Reaching it needs the downstream answers already set to blocked on both profitable outputs before the probe arrives, so that each hop is released and marked in turn. Contention is reached by raising two requests with the same single profitable direction in the same cycle. The loser must then see the output as taken and refuse. A second local probe, raised while the first local circuit is held, produces the busy refusal. A behavioural model in the bench, built from queues of candidate directions, predicts every port on every cycle.

// File: rtl/bts_pkg.sv
// Shared constants and types for the backtracking circuit-setup switch.
// Assumes five ports in a fixed order: local, +X, -X, +Y, -Y.
package bts_pkg;
    localparam int NPORT   = 5;
    localparam int P_LOCAL = 0;
    localparam int P_XPOS  = 1;
    localparam int P_XNEG  = 2;
    localparam int P_YPOS  = 3;
    localparam int P_YNEG  = 4;

    localparam logic [1:0] ANS_NONE  = 2'b00;
    localparam logic [1:0] ANS_READY = 2'b01;
    localparam logic [1:0] ANS_BLOCK = 2'b10;
    localparam logic [1:0] ANS_BUSY  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_HOLD,
        ST_REFUSE
    } chan_state_t;
endpackage

// File: rtl/bts_route.sv
// Candidate selector for one input channel.
// Given the probe destination, this node's address, the set of outputs already
// explored by the channel and the set held by any channel, it names the single
// output to try next (X before Y), or flags that none is left and which refusal
// code applies. Purely combinational; assumes no wrap-around links.
module bts_route
    import bts_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [2*CW-1:0]  dest,
    input  logic [2*CW-1:0]  here,
    input  logic [NPORT-1:0] tried,
    input  logic [NPORT-1:0] taken,
    output logic [NPORT-1:0] pick,
    output logic             dead,
    output logic [1:0]       dead_code
);
    localparam int AW = 2 * CW;

    logic [CW-1:0]    dx, dy, hx, hy;
    logic [NPORT-1:0] prof;
    logic [NPORT-1:0] avail;
    logic [NPORT-1:0] x_mask, y_mask;

    assign dx = dest[CW-1:0];
    assign dy = dest[AW-1:CW];
    assign hx = here[CW-1:0];
    assign hy = here[AW-1:CW];

    // Profitable directions: outputs that shorten the remaining distance.
    always_comb begin
        prof          = '0;
        prof[P_XPOS]  = dx > hx;
        prof[P_XNEG]  = dx < hx;
        prof[P_YPOS]  = dy > hy;
        prof[P_YNEG]  = dy < hy;
        x_mask        = '0;
        x_mask[P_XPOS] = 1'b1;
        x_mask[P_XNEG] = 1'b1;
        y_mask        = '0;
        y_mask[P_YPOS] = 1'b1;
        y_mask[P_YNEG] = 1'b1;
    end

    assign avail = prof & ~tried & ~taken;

    // Choose local delivery, an X hop, a Y hop, or a refusal.
    always_comb begin
        pick      = '0;
        dead      = 1'b0;
        dead_code = ANS_BLOCK;
        if (dest == here) begin
            if (tried[P_LOCAL]) begin
                dead = 1'b1;
            end else if (taken[P_LOCAL]) begin
                dead      = 1'b1;
                dead_code = ANS_BUSY;
            end else begin
                pick[P_LOCAL] = 1'b1;
            end
        end else if (|(avail & x_mask)) begin
            pick = avail & x_mask;
        end else if (|(avail & y_mask)) begin
            pick = avail & y_mask;
        end else begin
            dead = 1'b1;
        end
    end
endmodule

// File: rtl/bts_input_ctrl.sv
// Per-input search and hold controller.
// Latches the probe address when the request rises, searches through the
// selector, holds the granted output while the request stays high, backtracks
// on a blocked answer and refuses when nothing is left. The explored set lives
// here, so the probe never carries history.
module bts_input_ctrl
    import bts_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [2*CW-1:0]  hdr,
    input  logic [2*CW-1:0]  here,
    input  logic [NPORT-1:0] taken,
    input  logic             granted,
    input  logic [1:0]       down_ans,
    output logic [NPORT-1:0] want,
    output logic [NPORT-1:0] conn,
    output logic [1:0]       up_ans
);
    localparam int AW = 2 * CW;

    chan_state_t      state_q;
    logic [AW-1:0]    dest_q;
    logic [NPORT-1:0] tried_q;
    logic [NPORT-1:0] conn_q;
    logic [1:0]       code_q;
    logic [NPORT-1:0] pick;
    logic             dead;
    logic [1:0]       dead_code;

    bts_route #(.CW(CW)) u_route (
        .dest      (dest_q),
        .here      (here),
        .tried     (tried_q),
        .taken     (taken),
        .pick      (pick),
        .dead      (dead),
        .dead_code (dead_code)
    );

    // Channel state machine: idle, searching, holding, refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dest_q  <= '0;
            tried_q <= '0;
            conn_q  <= '0;
            code_q  <= ANS_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        dest_q  <= hdr;
                        tried_q <= '0;
                        state_q <= ST_SEEK;
                    end
                end
                ST_SEEK: begin
                    if (!req) begin
                        state_q <= ST_IDLE;
                    end else if (dead) begin
                        code_q  <= dead_code;
                        state_q <= ST_REFUSE;
                    end else if (granted) begin
                        conn_q  <= pick;
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!req) begin
                        conn_q  <= '0;
                        state_q <= ST_IDLE;
                    end else if (down_ans == ANS_BLOCK) begin
                        tried_q <= tried_q | conn_q;
                        conn_q  <= '0;
                        state_q <= ST_SEEK;
                    end
                end
                default: begin
                    if (!req) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Request toward the arbiter only while actively searching with a candidate.
    assign want = (state_q == ST_SEEK && req && !dead) ? pick : '0;
    assign conn = conn_q;

    // Upstream answer: relay while held (blocked is hidden), refusal code when refused.
    always_comb begin
        case (state_q)
            ST_HOLD:   up_ans = (down_ans == ANS_BLOCK) ? ANS_NONE : down_ans;
            ST_REFUSE: up_ans = code_q;
            default:   up_ans = ANS_NONE;
        endcase
    end
endmodule

// File: rtl/bts_xbar.sv
// Output arbiter and crossbar.
// Grants each contested output to the lowest-numbered wanting input, derives
// the held-output set from the inputs' registered connections, steers data
// forward and answers backward. Assumes each input holds at most one output.
module bts_xbar
    import bts_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [NPORT*NPORT-1:0] want,
    input  logic [NPORT*NPORT-1:0] conn,
    input  logic [NPORT*AW-1:0]    in_data,
    input  logic [2*NPORT-1:0]     in_ans,
    output logic [NPORT-1:0]       granted,
    output logic [NPORT-1:0]       taken,
    output logic [2*NPORT-1:0]     down_ans,
    output logic [NPORT-1:0]       out_req,
    output logic [NPORT*AW-1:0]    out_data
);
    logic [NPORT*NPORT-1:0] win;

    // Fixed-priority pick per output column: lowest input index wins.
    always_comb begin
        win = '0;
        for (int o = 0; o < NPORT; o++) begin
            logic seen;
            seen = 1'b0;
            for (int i = 0; i < NPORT; i++) begin
                win[i*NPORT+o] = want[i*NPORT+o] & ~seen;
                seen           = seen | want[i*NPORT+o];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_port
            // Grant to input g if it won its chosen column.
            assign granted[g] = |win[g*NPORT +: NPORT];

            // Output g is held when any input's connection names it.
            always_comb begin
                taken[g] = 1'b0;
                for (int i = 0; i < NPORT; i++) begin
                    taken[g] = taken[g] | conn[i*NPORT+g];
                end
            end

            // Forward data from the owning input to output g.
            always_comb begin
                out_data[g*AW +: AW] = '0;
                for (int i = 0; i < NPORT; i++) begin
                    if (conn[i*NPORT+g]) begin
                        out_data[g*AW +: AW] = out_data[g*AW +: AW] | in_data[i*AW +: AW];
                    end
                end
            end

            // Return the answer of input g's held output.
            always_comb begin
                down_ans[g*2 +: 2] = ANS_NONE;
                for (int o = 0; o < NPORT; o++) begin
                    if (conn[g*NPORT+o]) begin
                        down_ans[g*2 +: 2] = down_ans[g*2 +: 2] | in_ans[o*2 +: 2];
                    end
                end
            end
        end
    endgenerate

    assign out_req = taken;
endmodule

// File: rtl/bt_circuit_switch.sv
// Top of the backtracking circuit-setup switch controller.
// Five bidirectional ports (0 local, 1 +X, 2 -X, 3 +Y, 4 -Y). Each input owns a
// search controller; a shared arbiter/crossbar allocates outputs. node_addr is
// assumed static while any request is active.
module bt_circuit_switch
    import bts_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*CW-1:0]       node_addr,
    input  logic [NPORT-1:0]      in_req,
    input  logic [NPORT*2*CW-1:0] in_data,
    output logic [2*NPORT-1:0]    out_ans,
    output logic [NPORT-1:0]      out_req,
    output logic [NPORT*2*CW-1:0] out_data,
    input  logic [2*NPORT-1:0]    in_ans
);
    localparam int AW = 2 * CW;

    logic [NPORT*NPORT-1:0] want;
    logic [NPORT*NPORT-1:0] conn;
    logic [NPORT-1:0]       granted;
    logic [NPORT-1:0]       taken;
    logic [2*NPORT-1:0]     down_ans;

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_in
            bts_input_ctrl #(.CW(CW)) u_ctrl (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (in_req[g]),
                .hdr      (in_data[g*AW +: AW]),
                .here     (node_addr),
                .taken    (taken),
                .granted  (granted[g]),
                .down_ans (down_ans[g*2 +: 2]),
                .want     (want[g*NPORT +: NPORT]),
                .conn     (conn[g*NPORT +: NPORT]),
                .up_ans   (out_ans[g*2 +: 2])
            );
        end
    endgenerate

    bts_xbar #(.AW(AW)) u_xbar (
        .want     (want),
        .conn     (conn),
        .in_data  (in_data),
        .in_ans   (in_ans),
        .granted  (granted),
        .taken    (taken),
        .down_ans (down_ans),
        .out_req  (out_req),
        .out_data (out_data)
    );
endmodule

// File: rtl/bts_checker.sv
// Port-level temporal checks for the switch controller, bound to the top.
// Assumes the synchronous active-low reset of the top.
module bts_checker
    import bts_pkg::*;
#(
    parameter int CW = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPORT-1:0]      in_req,
    input logic [2*NPORT-1:0]    out_ans,
    input logic [NPORT-1:0]      out_req,
    input logic [NPORT*2*CW-1:0] out_data
);
    localparam int AW = 2 * CW;

    // Held outputs never outnumber the requests seen on the previous edge.
    p_circuits_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_req) <= $countones($past(in_req)));

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_chk
            // An input quiet for two samples answers nothing.
            p_quiet_after_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!in_req[g] && !$past(in_req[g])) |-> out_ans[g*2 +: 2] == ANS_NONE);

            // A ready answer implies some circuit is held.
            p_ready_needs_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_ans[g*2 +: 2] == ANS_READY) |-> (|out_req));

            // A held output follows a request present on the previous edge.
            p_held_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[g] |-> $past(|in_req));

            // An unowned output carries no data.
            p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !out_req[g] |-> out_data[g*AW +: AW] == '0);
        end
    endgenerate
endmodule

bind bt_circuit_switch bts_checker #(.CW(CW)) u_bts_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .out_ans  (out_ans),
    .out_req  (out_req),
    .out_data (out_data)
);

// File: tb/bt_circuit_switch_test.sv
// Bench: behavioural per-cycle model (queues of candidate directions) compared
// against every port at each falling edge.
module bt_circuit_switch_test;
    localparam int NP = 5;
    localparam int CW = 3;
    localparam int AW = 2 * CW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    node_addr;
    logic [NP-1:0]    in_req;
    logic [NP*AW-1:0] in_data;
    logic [2*NP-1:0]  out_ans;
    logic [NP-1:0]    out_req;
    logic [NP*AW-1:0] out_data;
    logic [2*NP-1:0]  in_ans;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    always #5 clk = ~clk;

    bt_circuit_switch #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .in_req(in_req),
        .in_data(in_data), .out_ans(out_ans), .out_req(out_req),
        .out_data(out_data), .in_ans(in_ans)
    );

    // Model state: 0 idle, 1 search, 2 held, 3 refused.
    int         m_st   [NP];
    int         m_sel  [NP];
    logic [5:0] m_dest [NP];
    logic [4:0] m_tried[NP];
    logic [1:0] m_code [NP];

    function automatic logic [AW-1:0] addr(int x, int y);
        return {3'(y), 3'(x)};
    endfunction

    function automatic void choose(input int i, input int own[NP],
                                   output int c, output logic [1:0] cd);
        int dx, dy, hx, hy;
        int order[$];
        dx = int'(m_dest[i][2:0]); dy = int'(m_dest[i][5:3]);
        hx = int'(node_addr[2:0]); hy = int'(node_addr[5:3]);
        c = -1; cd = 2'b10;
        if (m_dest[i] == node_addr) begin
            if (m_tried[i][0]) cd = 2'b10;
            else if (own[0] >= 0) cd = 2'b11;
            else c = 0;
            return;
        end
        if (dx > hx) order.push_back(1); else if (dx < hx) order.push_back(2);
        if (dy > hy) order.push_back(3); else if (dy < hy) order.push_back(4);
        foreach (order[k]) begin
            if (!m_tried[i][order[k]] && own[order[k]] < 0) begin
                c = order[k];
                return;
            end
        end
    endfunction

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        int own[NP];
        bit claim[NP];
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_st[i] = 0; m_sel[i] = -1; m_dest[i] = '0; m_tried[i] = '0; m_code[i] = '0;
            end
        end else begin
            for (int o = 0; o < NP; o++) begin own[o] = -1; claim[o] = 0; end
            for (int i = 0; i < NP; i++) if (m_sel[i] >= 0) own[m_sel[i]] = i;
            for (int i = 0; i < NP; i++) begin
                int c;
                logic [1:0] cd;
                case (m_st[i])
                    0: if (in_req[i]) begin
                        m_dest[i] = in_data[i*AW +: AW]; m_tried[i] = '0; m_st[i] = 1;
                    end
                    1: if (!in_req[i]) m_st[i] = 0;
                       else begin
                           choose(i, own, c, cd);
                           if (c < 0) begin m_code[i] = cd; m_st[i] = 3; end
                           else if (!claim[c]) begin claim[c] = 1; m_sel[i] = c; m_st[i] = 2; end
                       end
                    2: if (!in_req[i]) begin m_sel[i] = -1; m_st[i] = 0; end
                       else if (in_ans[m_sel[i]*2 +: 2] == 2'b10) begin
                           m_tried[i][m_sel[i]] = 1'b1; m_sel[i] = -1; m_st[i] = 1;
                       end
                    default: if (!in_req[i]) m_st[i] = 0;
                endcase
            end
        end
    end

    task automatic check();
        logic [NP-1:0]    e_req;
        logic [NP*AW-1:0] e_data;
        logic [2*NP-1:0]  e_ans;
        e_req = '0; e_data = '0; e_ans = '0;
        for (int i = 0; i < NP; i++) begin
            if (m_sel[i] >= 0) begin
                e_req[m_sel[i]] = 1'b1;
                e_data[m_sel[i]*AW +: AW] = in_data[i*AW +: AW];
            end
            if (m_st[i] == 2) begin
                logic [1:0] a;
                a = in_ans[m_sel[i]*2 +: 2];
                e_ans[i*2 +: 2] = (a == 2'b10) ? 2'b00 : a;
            end else if (m_st[i] == 3) begin
                e_ans[i*2 +: 2] = m_code[i];
            end
        end
        n_checks++;
        if (out_req !== e_req || out_data !== e_data || out_ans !== e_ans) begin
            n_fails++;
            $display("FAIL %s t=%0t req act=%b exp=%b ans act=%b exp=%b data act=%h exp=%h",
                     cur_req, $time, out_req, e_req, out_ans, e_ans, out_data, e_data);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check();
        end
    endtask

    task automatic setp(int p, bit r, logic [AW-1:0] d);
        in_req[p] = r;
        in_data[p*AW +: AW] = d;
    endtask

    task automatic seta(int o, logic [1:0] a);
        in_ans[o*2 +: 2] = a;
    endtask

    task automatic clear_all();
        in_req = '0; in_data = '0; in_ans = '0;
    endtask

    initial begin
        node_addr = addr(3, 3);
        clear_all();
        cur_req = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R11 then R2: probe from -X side toward (5,5), +X output answers ready.
        cur_req = "R11";
        setp(2, 1, addr(5, 5)); seta(1, 2'b01);
        cyc(2);
        cur_req = "R2";
        cyc(2);
        cur_req = "R10";
        setp(2, 1, 6'h2A); cyc(1);
        setp(2, 1, 6'h15); cyc(2);
        cur_req = "R9";
        setp(2, 0, '0); cyc(1); seta(1, 2'b00); cyc(2);

        // R2: toward smaller X uses -X output.
        cur_req = "R2";
        setp(1, 1, addr(0, 6)); seta(2, 2'b11); cyc(4);
        setp(1, 0, '0); seta(2, 2'b00); cyc(3);

        // R3: X matched, smaller Y uses -Y output, busy answer relayed.
        cur_req = "R3";
        setp(1, 1, addr(3, 1)); seta(4, 2'b11); cyc(4);
        setp(1, 0, '0); seta(4, 2'b00); cyc(3);

        // R4: local delivery, ready then busy relayed.
        cur_req = "R4";
        setp(1, 1, addr(3, 3)); seta(0, 2'b01); cyc(3);
        seta(0, 2'b11); cyc(2);
        setp(1, 0, '0); seta(0, 2'b00); cyc(3);

        // R5: +X blocks, probe backtracks onto +Y.
        cur_req = "R5";
        setp(0, 1, addr(5, 5)); seta(1, 2'b10); seta(3, 2'b01); cyc(7);
        setp(0, 0, '0); clear_all(); cyc(3);

        // R6: both profitable outputs block, refusal with 10.
        cur_req = "R6";
        setp(0, 1, addr(5, 5)); seta(1, 2'b10); seta(3, 2'b10); cyc(9);
        setp(0, 0, '0); clear_all(); cyc(3);

        // R7: two inputs contend for +X; lower index wins, other refuses.
        cur_req = "R7";
        setp(3, 1, addr(5, 3)); setp(4, 1, addr(5, 3)); seta(1, 2'b01); cyc(6);
        setp(3, 0, '0); setp(4, 0, '0); clear_all(); cyc(3);

        // R8: second local probe while local port held gets 11.
        cur_req = "R8";
        setp(1, 1, addr(3, 3)); seta(0, 2'b01); cyc(3);
        setp(2, 1, addr(3, 3)); cyc(4);
        setp(1, 0, '0); setp(2, 0, '0); clear_all(); cyc(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule